// File: doc/BRIEF.md
# Half-Duplex Three-Wire Serial Master

This block is a serial bus master. It drives a clock line and shares a single bidirectional data line with one attached device. Each command starts one bus transaction. In sequential mode the transaction sends a run of outgoing bytes and then receives a run of incoming bytes. In in-place mode, each byte position sends one outgoing byte and then at once receives the byte that replaces it.

Outgoing bytes arrive on a ready/valid stream. Received bytes leave on a one-cycle valid strobe. A single-cycle `done` pulse closes every transaction. The block drives an output-enable for the data pad, so the pad is driven during outgoing bytes and released during incoming ones.

Every clock phase lasts a number of system-clock ticks. The command supplies this count, and 32 is the customary value. A down-counter times each phase, so the bus rate changes with no change to the logic. The serial clock idles high. Outgoing data is placed on the line before the falling edge. Incoming data is taken at the end of the high phase.

Top module: `hd3w_spi_master`

## Requirements
- R1: `sclk` is 1 while reset is asserted and at every cycle in which the block is idle (`cmd_ready` high).
- R2: Outgoing bytes are shifted most-significant bit first, eight bits per byte. The device captures `sdo` on each rising `sclk`, and the captured bytes equal the accepted `tx_data` bytes in order.
- R3: Each outgoing bit has three phases. First, `sdo` holds the bit with `sclk` high for one phase. Then `sclk` is low for one phase. Then `sclk` is high for one phase. `sdo` does not change while `sclk` is low.
- R4: Each incoming bit has two phases: `sclk` low for one phase, then high for one phase. `sdi` is sampled at the end of the high phase, most-significant bit first.
- R5: `sdo_oe` is 1 for every bit of an outgoing byte and 0 for every bit of an incoming byte. It never changes during a low phase of `sclk`.
- R6: In sequential mode (`cmd_inplace`=0), every outgoing byte is finished before the first incoming bit is clocked.
- R7: In in-place mode (`cmd_inplace`=1), each of the `cmd_wr_len` positions sends one byte and then receives one byte before the next position starts. `cmd_rd_len` is ignored in this mode.
- R8: Each `sclk` phase lasts exactly `cmd_phase_ticks` system-clock cycles. The value is captured when the command is accepted, and a value of 0 acts as 1.
- R9: With no stalls, `done` is high for one cycle at a fixed cycle index, counting the cycle after the accept edge as index 0. In sequential mode the index is W·(1+24T) + R·16T. In in-place mode it is W·(1+40T). After `done`, the block is idle with `sdo_oe`=0.
- R10: While `tx_valid` is low at the start of an outgoing byte, `tx_ready` stays high, `sclk` stays high and `sdo_oe` is 0. No partial bit is issued.
- R11: A phase with a length of zero is skipped. A command with both lengths zero raises `done` in the first cycle after acceptance.
- R12: Each completed incoming byte gives exactly one cycle of `rx_valid`, with the byte on `rx_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Block idle, command accepted when valid |
| cmd_inplace | input | 1 | 1 = in-place mode, 0 = sequential mode |
| cmd_wr_len | input | CNT_W | Outgoing byte count (position count in in-place mode) |
| cmd_rd_len | input | CNT_W | Incoming byte count (sequential mode only) |
| cmd_phase_ticks | input | TICK_W | System clocks per serial clock phase |
| tx_data | input | 8 | Outgoing byte |
| tx_valid | input | 1 | Outgoing byte available |
| tx_ready | output | 1 | Outgoing byte taken when valid |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| done | output | 1 | One-cycle end-of-transaction pulse |
| sclk | output | 1 | Serial clock, idles high |
| sdo | output | 1 | Data value for the shared pad |
| sdo_oe | output | 1 | Pad output enable |
| sdi | input | 1 | Data value read from the shared pad |

## Verification
The hardest case to reach is the hand-over of direction inside in-place transfers. The pad enable must drop between the last rising edge of an outgoing byte and the first falling edge of the incoming byte. Then, after the incoming byte, the block must wait again for a fresh outgoing byte. The bench reaches this case by sweeping every mix of zero to three outgoing and incoming bytes in both modes, at three phase lengths. A device model checks at the first incoming bit how many outgoing bytes it has already captured. Separate runs hold `tx_valid` low for several cycles before each byte, which keeps the block parked at a byte boundary.

// File: rtl/hd3w_pkg.sv
package hd3w_pkg;

    localparam int BYTE_W    = 8;
    localparam int BIT_IDX_W = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WSETUP,
        ST_WLOW,
        ST_WHIGH,
        ST_RLOW,
        ST_RHIGH,
        ST_DONE
    } hd3w_state_e;

endpackage

// File: rtl/hd3w_phase_timer.sv
module hd3w_phase_timer #(
    parameter int TICK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [TICK_W-1:0] ticks,
    output logic              expire
);

    logic [TICK_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = ticks - TICK_W'(1);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - TICK_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expire = (cnt_q == '0);

endmodule

// File: rtl/hd3w_shifter.sv
module hd3w_shifter #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             shift,
    input  logic [WIDTH-1:0] load_val,
    input  logic             din,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load) begin
            sh_d = load_val;
        end else if (shift) begin
            sh_d = {sh_q[WIDTH-2:0], din};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign q = sh_q;

endmodule

// File: rtl/hd3w_spi_master.sv
module hd3w_spi_master
    import hd3w_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int TICK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_inplace,
    input  logic [CNT_W-1:0]  cmd_wr_len,
    input  logic [CNT_W-1:0]  cmd_rd_len,
    input  logic [TICK_W-1:0] cmd_phase_ticks,
    input  logic [7:0]        tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic [7:0]        rx_data,
    output logic              rx_valid,
    output logic              done,
    output logic              sclk,
    output logic              sdo,
    output logic              sdo_oe,
    input  logic              sdi
);

    typedef struct packed {
        hd3w_state_e          state;
        logic [BIT_IDX_W-1:0] bit_idx;
        logic [CNT_W-1:0]     wr_left;
        logic [CNT_W-1:0]     rd_left;
        logic                 inplace;
        logic [TICK_W-1:0]    ticks;
        logic                 rx_vld;
    } ctl_t;

    localparam ctl_t CTL_RST = '{state: ST_IDLE, default: '0};

    ctl_t r_d, r_q;

    logic              tmr_load, tmr_expire;
    logic [TICK_W-1:0] tmr_ticks, eff_ticks;
    logic              sh_load, sh_shift;
    logic [BYTE_W-1:0] sh_q;

    hd3w_phase_timer #(.TICK_W(TICK_W)) i_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (tmr_load),
        .ticks  (tmr_ticks),
        .expire (tmr_expire)
    );

    hd3w_shifter #(.WIDTH(BYTE_W)) i_shifter (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .shift    (sh_shift),
        .load_val (tx_data),
        .din      (sdi),
        .q        (sh_q)
    );

    always_comb begin
        r_d        = r_q;
        r_d.rx_vld = 1'b0;
        tmr_load   = 1'b0;
        sh_load    = 1'b0;
        sh_shift   = 1'b0;
        cmd_ready  = 1'b0;
        tx_ready   = 1'b0;
        done       = 1'b0;
        sclk       = 1'b1;
        sdo_oe     = 1'b0;
        eff_ticks  = (cmd_phase_ticks == '0) ? TICK_W'(1) : cmd_phase_ticks;
        tmr_ticks  = (r_q.state == ST_IDLE) ? eff_ticks : r_q.ticks;

        unique case (r_q.state)
            ST_IDLE: begin
                cmd_ready = 1'b1;
                if (cmd_valid) begin
                    r_d.inplace = cmd_inplace;
                    r_d.ticks   = eff_ticks;
                    r_d.wr_left = cmd_wr_len;
                    r_d.rd_left = cmd_inplace ? '0 : cmd_rd_len;
                    r_d.bit_idx = '1;
                    if (cmd_wr_len != '0) begin
                        r_d.state = ST_FETCH;
                    end else if (!cmd_inplace && cmd_rd_len != '0) begin
                        r_d.state = ST_RLOW;
                        tmr_load  = 1'b1;
                    end else begin
                        r_d.state = ST_DONE;
                    end
                end
            end
            ST_FETCH: begin
                tx_ready = 1'b1;
                if (tx_valid) begin
                    sh_load     = 1'b1;
                    tmr_load    = 1'b1;
                    r_d.bit_idx = '1;
                    r_d.state   = ST_WSETUP;
                end
            end
            ST_WSETUP: begin
                sdo_oe = 1'b1;
                if (tmr_expire) begin
                    tmr_load  = 1'b1;
                    r_d.state = ST_WLOW;
                end
            end
            ST_WLOW: begin
                sdo_oe = 1'b1;
                sclk   = 1'b0;
                if (tmr_expire) begin
                    tmr_load  = 1'b1;
                    r_d.state = ST_WHIGH;
                end
            end
            ST_WHIGH: begin
                sdo_oe = 1'b1;
                if (tmr_expire) begin
                    if (r_q.bit_idx == '0) begin
                        r_d.wr_left = r_q.wr_left - CNT_W'(1);
                        r_d.bit_idx = '1;
                        if (r_q.inplace) begin
                            tmr_load  = 1'b1;
                            r_d.state = ST_RLOW;
                        end else if (r_q.wr_left != CNT_W'(1)) begin
                            r_d.state = ST_FETCH;
                        end else if (r_q.rd_left != '0) begin
                            tmr_load  = 1'b1;
                            r_d.state = ST_RLOW;
                        end else begin
                            r_d.state = ST_DONE;
                        end
                    end else begin
                        sh_shift    = 1'b1;
                        tmr_load    = 1'b1;
                        r_d.bit_idx = r_q.bit_idx - BIT_IDX_W'(1);
                        r_d.state   = ST_WSETUP;
                    end
                end
            end
            ST_RLOW: begin
                sclk = 1'b0;
                if (tmr_expire) begin
                    tmr_load  = 1'b1;
                    r_d.state = ST_RHIGH;
                end
            end
            ST_RHIGH: begin
                if (tmr_expire) begin
                    sh_shift = 1'b1;
                    if (r_q.bit_idx == '0) begin
                        r_d.rx_vld  = 1'b1;
                        r_d.bit_idx = '1;
                        if (r_q.inplace) begin
                            r_d.state = (r_q.wr_left != '0) ? ST_FETCH : ST_DONE;
                        end else begin
                            r_d.rd_left = r_q.rd_left - CNT_W'(1);
                            if (r_q.rd_left != CNT_W'(1)) begin
                                tmr_load  = 1'b1;
                                r_d.state = ST_RLOW;
                            end else begin
                                r_d.state = ST_DONE;
                            end
                        end
                    end else begin
                        tmr_load    = 1'b1;
                        r_d.bit_idx = r_q.bit_idx - BIT_IDX_W'(1);
                        r_d.state   = ST_RLOW;
                    end
                end
            end
            ST_DONE: begin
                done      = 1'b1;
                r_d.state = ST_IDLE;
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase

        sdo = sdo_oe & sh_q[BYTE_W-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= CTL_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign rx_data  = sh_q;
    assign rx_valid = r_q.rx_vld;

endmodule

// File: rtl/hd3w_checker.sv
module hd3w_checker (
    input logic clk,
    input logic rst_n,
    input logic cmd_ready,
    input logic tx_ready,
    input logic done,
    input logic sclk,
    input logic sdo,
    input logic sdo_oe,
    input logic rx_valid
);

    a_r1_idle_clock_high: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> sclk);

    a_r1_ready_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !tx_ready);

    a_r3_data_stable_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk && sdo_oe) |-> $stable(sdo));

    a_r5_oe_steady_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk && $past(!sclk)) |-> $stable(sdo_oe));

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_done_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (cmd_ready && !sdo_oe));

    a_r10_stall_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> (sclk && !sdo_oe));

    a_r12_rx_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

endmodule

bind hd3w_spi_master hd3w_checker i_hd3w_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_ready (cmd_ready),
    .tx_ready  (tx_ready),
    .done      (done),
    .sclk      (sclk),
    .sdo       (sdo),
    .sdo_oe    (sdo_oe),
    .rx_valid  (rx_valid)
);

// File: tb/test_hd3w_spi_master.sv
module test_hd3w_spi_master;

    localparam int CNT_W  = 8;
    localparam int TICK_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic              cmd_ready;
    logic              cmd_inplace = 1'b0;
    logic [CNT_W-1:0]  cmd_wr_len = '0;
    logic [CNT_W-1:0]  cmd_rd_len = '0;
    logic [TICK_W-1:0] cmd_phase_ticks = '0;
    logic [7:0]        tx_data = '0;
    logic              tx_valid = 1'b0;
    logic              tx_ready;
    logic [7:0]        rx_data;
    logic              rx_valid;
    logic              done;
    logic              sclk;
    logic              sdo;
    logic              sdo_oe;
    logic              sdi = 1'b0;

    always #4 clk = ~clk;

    hd3w_spi_master #(.CNT_W(CNT_W), .TICK_W(TICK_W)) i_hd3w_spi_master (
        .clk, .rst_n, .cmd_valid, .cmd_ready, .cmd_inplace, .cmd_wr_len,
        .cmd_rd_len, .cmd_phase_ticks, .tx_data, .tx_valid, .tx_ready,
        .rx_data, .rx_valid, .done, .sclk, .sdo, .sdo_oe, .sdi
    );

    int n_checks = 0;
    int n_fail   = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] tx_val(input int g);
        return 8'((g * 29 + 90) % 256);
    endfunction

    function automatic logic [7:0] resp_val(input int g);
        return 8'((g * 53 + 60) % 256);
    endfunction

    // transaction context, written only by the run task
    int t_wbase = 0, t_rbase = 0, t_inplace = 0, t_wr = 0, t_d = 1;

    // device model: cumulative counters
    int         dev_wbits = 0, dev_wbytes = 0, dev_rbits = 0, dev_rbytes = 0;
    logic [7:0] dev_wsh = '0;
    int         rx_cnt = 0;
    int         low_run = 0;

    always @(posedge sclk) begin
        if (sdo_oe === 1'b1) begin
            dev_wsh = {dev_wsh[6:0], sdo};
            dev_wbits++;
            if (dev_wbits == 8) begin
                // R2: MSB-first capture equals accepted byte
                chk(dev_wsh == tx_val(dev_wbytes), "R2", int'(dev_wsh), int'(tx_val(dev_wbytes)));
                dev_wbytes++;
                dev_wbits = 0;
            end
        end
    end

    always @(negedge sclk) begin
        if (sdo_oe === 1'b0) begin
            logic [7:0] b;
            if (dev_rbits == 0) begin
                if (t_inplace != 0)
                    chk(dev_wbytes - t_wbase == dev_rbytes - t_rbase + 1, "R7",
                        dev_wbytes - t_wbase, dev_rbytes - t_rbase + 1);
                else
                    chk(dev_wbytes - t_wbase == t_wr, "R6", dev_wbytes - t_wbase, t_wr);
            end
            b   = resp_val(dev_rbytes);
            sdi = b[7 - dev_rbits];
            dev_rbits++;
            if (dev_rbits == 8) begin
                dev_rbits = 0;
                dev_rbytes++;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin
                // R12 / R4: received byte matches device response
                chk(rx_data == resp_val(rx_cnt), "R12", int'(rx_data), int'(resp_val(rx_cnt)));
                rx_cnt++;
            end
            if (!sclk) begin
                low_run++;
            end else if (low_run > 0) begin
                chk(low_run == t_d, "R8", low_run, t_d);
                low_run = 0;
            end
        end
    end

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 190000) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", wd, 190000);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic run(input int inpl, input int wr, input int rd, input int ticks, input int stall);
        int  d     = (ticks == 0) ? 1 : ticks;
        int  n_rd  = (inpl != 0) ? wr : rd;
        int  xbase = rx_cnt;
        int  cnt   = -1;
        int  tx_idx = 0;
        int  stall_left = 0;
        int  exp_cyc;
        bit  hs_pending = 1'b0;
        @(negedge clk);
        t_wbase   = dev_wbytes;
        t_rbase   = dev_rbytes;
        t_inplace = inpl;
        t_wr      = wr;
        t_d       = d;
        if (wr > 0) begin
            if (stall == 0) begin
                tx_valid = 1'b1;
                tx_data  = tx_val(t_wbase);
            end else begin
                tx_valid   = 1'b0;
                stall_left = stall;
            end
        end
        cmd_valid       = 1'b1;
        cmd_inplace     = inpl[0];
        cmd_wr_len      = CNT_W'(wr);
        cmd_rd_len      = CNT_W'(rd);
        cmd_phase_ticks = TICK_W'(ticks);
        forever begin
            @(negedge clk);
            cmd_valid = 1'b0;
            cnt++;
            if (hs_pending) begin
                hs_pending = 1'b0;
                tx_idx++;
                if (tx_idx < wr) begin
                    if (stall == 0) begin
                        tx_data = tx_val(t_wbase + tx_idx);
                    end else begin
                        tx_valid   = 1'b0;
                        stall_left = stall;
                    end
                end else begin
                    tx_valid = 1'b0;
                end
            end else if (stall_left > 0) begin
                stall_left--;
                if (stall_left == 0) begin
                    tx_valid = 1'b1;
                    tx_data  = tx_val(t_wbase + tx_idx);
                end
            end
            if (tx_ready && !tx_valid)
                chk(sclk === 1'b1 && sdo_oe === 1'b0, "R10", int'(sclk), 1);
            if (tx_valid && tx_ready) hs_pending = 1'b1;
            if (done) break;
            if (cnt > 60000) break;
        end
        exp_cyc = (inpl != 0) ? wr * (1 + 40 * d) : wr * (1 + 24 * d) + rd * 16 * d;
        if (stall == 0) begin
            if (wr == 0 && n_rd == 0)
                chk(cnt == 0, "R11", cnt, 0);
            else
                chk(cnt == exp_cyc, "R9", cnt, exp_cyc);
        end
        @(negedge clk);
        @(negedge clk);
        chk(dev_wbytes - t_wbase == wr, "R2", dev_wbytes - t_wbase, wr);
        chk(dev_rbytes - t_rbase == n_rd, (inpl != 0) ? "R7" : "R4", dev_rbytes - t_rbase, n_rd);
        chk(rx_cnt - xbase == n_rd, "R12", rx_cnt - xbase, n_rd);
        chk(sclk === 1'b1 && cmd_ready === 1'b1, "R1", int'(sclk), 1);
        chk(sdo_oe === 1'b0 && done === 1'b0, "R9", int'(sdo_oe), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(sclk === 1'b1, "R1", int'(sclk), 1);
        chk(sdo_oe === 1'b0, "R5", int'(sdo_oe), 0);
        chk(done === 1'b0 && rx_valid === 1'b0, "R9", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_ready === 1'b1 && sclk === 1'b1, "R1", int'(cmd_ready), 1);

        for (int d = 1; d <= 3; d++)
            for (int m = 0; m <= 1; m++)
                for (int w = 0; w <= 3; w++)
                    for (int r = 0; r <= 3; r++)
                        run(m, w, r, d, 0);

        run(0, 3, 2, 2, 5);   // R10 stalls, sequential
        run(1, 2, 3, 1, 3);   // R10 stalls, in-place, R7 ignores rd length
        run(0, 1, 1, 32, 0);  // R8 customary phase length
        run(1, 1, 0, 32, 0);
        run(0, 2, 1, 0, 0);   // R8 zero ticks act as one
        run(0, 0, 0, 5, 0);   // R11

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule